// File: doc/BRIEF.md
# Root Port Legacy Interrupt Queue Registers

This block is the interrupt-reporting register set of a PCIe root port bridge. Legacy INTx events arrive as single-cycle pulses, each carrying a 2-bit lane number and an assert/deassert level. They are held in a small circular queue until software reads them. Software looks at the oldest event through two 32-bit queue read registers. A write of any value to either register retires that event.

A pending-interrupt decode register and an interrupt mask register combine into one level interrupt output. The decode register's INTx bit is set again whenever the queue still holds work. A root-port status/control register holds a bridge-enable bit, which is exported as an output, together with queue-empty and overflow status. A PHY status register shows a link-up input. All registers are reached through a plain 32-bit address/data port. Writes are applied at the clock edge, and read data is a combinational function of the address and the current state.

Top module: `rp_intx_queue`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: decode, mask, queue contents, overflow flag and bridge enable. The interrupt output is low and the empty bit (bit 18 at 0x148) reads 1.
- R2: Registers sit at these offsets: decode 0x138, mask 0x13C, PHY status 0x144, port status/control 0x148, queue word 1 at 0x158, queue word 2 at 0x15C. PHY status bit 11 shows the link-up input. Any other address reads 0, and writes to it change nothing. Read data is 0 when no read is requested.
- R3: The queue holds at most DEPTH-1 events. An event that arrives while it holds DEPTH-1 is dropped and sets overflow bit 19 at 0x148. That flag clears only on reset.
- R4: Queue word 1 of a held event has the valid flag at bit 31, the level at bit 29 and the lane at bits 28:27. All other bits are 0. Queue word 2 always reads 0.
- R5: Reading a queue word returns the oldest event and does not remove it. With an empty queue, both words read 0.
- R6: A write of any value to 0x158 or 0x15C removes the oldest event. When the queue is empty, the write has no effect.
- R7: An accepted event sets decode bit 16. A decode write clears every bit that is 1 in the written data. A write to decode or mask, or an accepted event, leaves bit 16 at 1 whenever the queue holds an event after that cycle.
- R8: The mask register is read/write. The interrupt output is high exactly when decode bit 16 and mask bit 16 are both 1. Decode bit 17 always reads 0.
- R9: Bit 18 at 0x148 reads 1 when the queue is empty and 0 when it holds events.
- R10: Bit 0 at 0x148 is a read/write bridge enable, driven on the bridge-enable output. A write to 0x148 changes no other state.
- R11: If an event and a removal happen in the same cycle, both take effect. Whether the event is accepted depends on the occupancy before that cycle, so an event is still dropped when the queue is full, even if a removal happens at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | One-cycle INTx event strobe |
| evt_lane | input | 2 | Lane number of the event |
| evt_level | input | 1 | 1 = assert, 0 = deassert |
| link_up | input | 1 | Link status shown at 0x144 bit 11 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |
| bridge_en | output | 1 | Bridge enable from 0x148 bit 0 |

## Verification
The assertions assume that the event strobe and the register strobes are sampled cleanly at the clock edge. They also assume that the register address is stable whenever a strobe is high, so that a removal and an event in the same cycle are defined. The stimulus changes every input only at the falling edge. It drives exactly one register access per cycle, and it raises events alone, while the queue is full, and together with removals. This covers the full-queue window that the occupancy properties look at.

// File: rtl/rpq_pkg.sv
// Package: shared offsets, field positions and the queued event type.
// Assumes a 12-bit byte address; only exact offsets decode.
package rpq_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DECODE = 12'h138;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h13C;
    localparam logic [ADDR_W-1:0] OFS_PHY    = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_PORT   = 12'h148;
    localparam logic [ADDR_W-1:0] OFS_QWORD1 = 12'h158;
    localparam logic [ADDR_W-1:0] OFS_QWORD2 = 12'h15C;

    localparam int BIT_INTX   = 16;
    localparam int BIT_LINK   = 11;
    localparam int BIT_BRIDGE = 0;
    localparam int BIT_EMPTY  = 18;
    localparam int BIT_OVF    = 19;
    localparam int POS_LANE   = 27;
    localparam int POS_LEVEL  = 29;
    localparam int POS_VALID  = 31;

    typedef struct packed {
        logic       level;
        logic [1:0] lane;
    } intx_evt_t;
endpackage

// File: rtl/rpq_fifo.sv
// Module: circular event queue with read/write pointers and an occupancy count.
// One slot is kept free: capacity is DEPTH-1. Accept/drop is decided on the
// occupancy before the cycle, so a push and a pop in the same cycle both act.
// Assumes DEPTH >= 2.
module rpq_fifo
    import rpq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  intx_evt_t                    evt_i,
    input  logic                         pop_i,
    output logic                         push_ok_o,
    output logic                         dropped_o,
    output intx_evt_t                    head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         empty_o,
    output logic                         next_nonempty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH - 1);

    logic [PW-1:0] rptr, wptr;
    logic [CW-1:0] cnt, cnt_next;
    intx_evt_t     slots [DEPTH];
    logic          full, pop_ok;

    function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (cnt == CAP);
    assign empty_o   = (cnt == '0);
    assign push_ok_o = push_i && !full;
    assign dropped_o = push_i && full;
    assign pop_ok    = pop_i && !empty_o;
    assign head_o    = slots[rptr];
    assign count_o   = cnt;

    // Purpose: next occupancy from accepted push and effective pop.
    always_comb begin
        cnt_next = cnt;
        if (push_ok_o && !pop_ok)      cnt_next = cnt + 1'b1;
        else if (!push_ok_o && pop_ok) cnt_next = cnt - 1'b1;
    end

    assign next_nonempty_o = (cnt_next != '0);

    // Purpose: pointer and count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok_o) wptr <= advance(wptr);
            if (pop_ok)    rptr <= advance(rptr);
            cnt <= cnt_next;
        end
    end

    // Purpose: event storage, written at the write pointer on accept.
    always_ff @(posedge clk) begin
        if (push_ok_o) slots[wptr] <= evt_i;
    end
endmodule

// File: rtl/rpq_irq_ctrl.sv
// Module: decode-pending INTx bit, mask register and the level interrupt.
// Bit 16 is the only decode bit that can be set; it is re-set after any
// decode/mask write or accepted push while the queue stays non-empty.
module rpq_irq_ctrl
    import rpq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_wr_i,
    input  logic              dec_clr_i,
    input  logic              mask_wr_i,
    input  logic [DATA_W-1:0] mask_wdata_i,
    input  logic              push_ok_i,
    input  logic              refill_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);
    logic pend_next;

    // Purpose: next pending bit: clear, set on accept, refill if queue busy.
    always_comb begin
        pend_next = pend_o;
        if (dec_wr_i && dec_clr_i) pend_next = 1'b0;
        if (push_ok_i)             pend_next = 1'b1;
        if ((dec_wr_i || mask_wr_i || push_ok_i) && refill_i) pend_next = 1'b1;
    end

    // Purpose: pending bit and mask register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            mask_o <= '0;
        end else begin
            pend_o <= pend_next;
            if (mask_wr_i) mask_o <= mask_wdata_i;
        end
    end

    assign irq_o = pend_o && mask_o[BIT_INTX];
endmodule

// File: rtl/rp_intx_queue.sv
// Module: top of the root-port interrupt queue register set.
// Decodes the register port, keeps the bridge-enable and overflow bits,
// and forms combinational read data. Assumes one access per cycle.
module rp_intx_queue
    import rpq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_lane,
    input  logic              evt_level,
    input  logic              link_up,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              bridge_en
);
    localparam int CW = $clog2(DEPTH+1);

    logic              hit_dec, hit_mask, hit_port, hit_q;
    logic              push_ok, dropped, q_empty, next_nonempty;
    logic [CW-1:0]     q_count;
    intx_evt_t         evt_in, head;
    logic              pend;
    logic [DATA_W-1:0] mask_q;
    logic              ovf_flag;
    logic [DATA_W-1:0] rd_val;

    assign hit_dec  = bus_wr && (bus_addr == OFS_DECODE);
    assign hit_mask = bus_wr && (bus_addr == OFS_MASK);
    assign hit_port = bus_wr && (bus_addr == OFS_PORT);
    assign hit_q    = bus_wr && ((bus_addr == OFS_QWORD1) || (bus_addr == OFS_QWORD2));

    assign evt_in.level = evt_level;
    assign evt_in.lane  = evt_lane;

    rpq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_i          (evt_valid),
        .evt_i           (evt_in),
        .pop_i           (hit_q),
        .push_ok_o       (push_ok),
        .dropped_o       (dropped),
        .head_o          (head),
        .count_o         (q_count),
        .empty_o         (q_empty),
        .next_nonempty_o (next_nonempty)
    );

    rpq_irq_ctrl u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_wr_i     (hit_dec),
        .dec_clr_i    (bus_wdata[BIT_INTX]),
        .mask_wr_i    (hit_mask),
        .mask_wdata_i (bus_wdata),
        .push_ok_i    (push_ok),
        .refill_i     (next_nonempty),
        .pend_o       (pend),
        .mask_o       (mask_q),
        .irq_o        (irq)
    );

    // Purpose: bridge-enable bit and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bridge_en <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (hit_port) bridge_en <= bus_wdata[BIT_BRIDGE];
            if (dropped)  ovf_flag  <= 1'b1;
        end
    end

    // Purpose: read multiplexer over the register map.
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            OFS_DECODE: rd_val[BIT_INTX] = pend;
            OFS_MASK:   rd_val = mask_q;
            OFS_PHY:    rd_val[BIT_LINK] = link_up;
            OFS_PORT: begin
                rd_val[BIT_BRIDGE] = bridge_en;
                rd_val[BIT_EMPTY]  = q_empty;
                rd_val[BIT_OVF]    = ovf_flag;
            end
            OFS_QWORD1: if (!q_empty) begin
                rd_val[POS_VALID]             = 1'b1;
                rd_val[POS_LEVEL]             = head.level;
                rd_val[POS_LANE+1:POS_LANE]   = head.lane;
            end
            default: rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_val : '0;
endmodule

// File: rtl/rpq_checker.sv
// Module: property checker for rp_intx_queue, attached by bind.
// Observes ports plus the queue occupancy and overflow flag.
module rpq_checker
    import rpq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       evt_valid,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       irq,
    input logic                       bridge_en,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       ovf
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH - 1);

    logic qwr;
    assign qwr = bus_wr && ((bus_addr == OFS_QWORD1) || (bus_addr == OFS_QWORD2));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && count == CAP) |=> ovf);

    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (qwr && count == '0 && !evt_valid) |=> count == '0);

    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && qwr && count != '0 && count < CAP) |=> count == $past(count));

    assert_bridge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PORT) |=> bridge_en == $past(bus_wdata[BIT_BRIDGE]));

    assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK && !bus_wdata[BIT_INTX]) |=> !irq);
endmodule

bind rp_intx_queue rpq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .bridge_en (bridge_en),
    .count     (q_count),
    .ovf       (ovf_flag)
);

// File: tb/tb_rp_intx_queue.sv
// Bench: behavioural reference model (queue + flags) compared every cycle.
module tb_rp_intx_queue;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_lane = '0;
    logic        evt_level = 1'b0;
    logic        link_up = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        bridge_en;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // Reference model state
    logic [2:0]  m_q[$];
    logic        m_pend, m_br, m_ovf;
    logic [31:0] m_mask;

    always #10 clk = ~clk;

    rp_intx_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_lane(evt_lane),
        .evt_level(evt_level), .link_up(link_up), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .bridge_en(bridge_en)
    );

    function automatic logic [31:0] exp_read(input logic rd, input logic [11:0] a);
        logic [31:0] v = '0;
        if (!rd) return '0;
        case (a)
            12'h138: v[16] = m_pend;
            12'h13C: v = m_mask;
            12'h144: v[11] = link_up;
            12'h148: begin v[0] = m_br; v[18] = (m_q.size() == 0); v[19] = m_ovf; end
            12'h158: if (m_q.size() != 0) v = {1'b1, 1'b0, m_q[0][2], m_q[0][1:0], 27'b0};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_q.delete();
        m_pend = 1'b0; m_br = 1'b0; m_ovf = 1'b0; m_mask = '0;
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input string req, input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] wd, input logic ev, input logic [1:0] ln, input logic lv);
        logic push_ok, pop, qwr;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        evt_valid = ev; evt_lane = ln; evt_level = lv;
        #2;
        check(req, "rdata", bus_rdata, exp_read(rd, a));
        check(req, "irq", {31'b0, irq}, {31'b0, m_pend & m_mask[16]});
        check(req, "bridge_en", {31'b0, bridge_en}, {31'b0, m_br});
        @(posedge clk);
        qwr     = wr && (a == 12'h158 || a == 12'h15C);
        push_ok = ev && (m_q.size() < DEPTH - 1);
        pop     = qwr && (m_q.size() > 0);
        if (ev && !push_ok) m_ovf = 1'b1;
        if (wr && a == 12'h138 && wd[16]) m_pend = 1'b0;
        if (pop) void'(m_q.pop_front());
        if (push_ok) begin m_q.push_back({lv, ln}); m_pend = 1'b1; end
        if (((wr && a == 12'h138) || (wr && a == 12'h13C) || push_ok) && m_q.size() > 0) m_pend = 1'b1;
        if (wr && a == 12'h13C) m_mask = wd;
        if (wr && a == 12'h148) m_br = wd[0];
    endtask

    task automatic rd_reg(input string req, input logic [11:0] a);
        step(req, 1'b0, 1'b1, a, '0, 1'b0, 2'd0, 1'b0);
    endtask
    task automatic wr_reg(input string req, input logic [11:0] a, input logic [31:0] d);
        step(req, 1'b1, 1'b0, a, d, 1'b0, 2'd0, 1'b0);
    endtask
    task automatic event_in(input string req, input logic [1:0] ln, input logic lv);
        step(req, 1'b0, 1'b1, 12'h148, '0, 1'b1, ln, lv);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; evt_valid = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: reset state of every register
        rd_reg("R1", 12'h138); rd_reg("R1", 12'h13C); rd_reg("R1", 12'h148);
        rd_reg("R1", 12'h158); rd_reg("R1", 12'h15C);
        // R2: map, link bit, unused address, no read strobe
        rd_reg("R2", 12'h144);
        link_up = 1'b0; rd_reg("R2", 12'h144); link_up = 1'b1;
        wr_reg("R2", 12'h100, 32'hFFFF_FFFF); rd_reg("R2", 12'h100);
        step("R2", 1'b0, 1'b0, 12'h13C, '0, 1'b0, 2'd0, 1'b0);
        // R4/R5: encoding and peek without removal
        event_in("R4", 2'd1, 1'b1);
        rd_reg("R4", 12'h158); rd_reg("R5", 12'h158); rd_reg("R4", 12'h15C);
        rd_reg("R9", 12'h148); rd_reg("R7", 12'h138);
        event_in("R4", 2'd2, 1'b0); event_in("R4", 2'd3, 1'b1);
        // R8: mask enables interrupt
        wr_reg("R8", 12'h13C, 32'h0001_0000); rd_reg("R8", 12'h13C);
        // R7: W1C with entries left refills
        wr_reg("R7", 12'h138, 32'hFFFF_FFFF); rd_reg("R7", 12'h138);
        // R6: pops via both words
        wr_reg("R6", 12'h15C, 32'h0); rd_reg("R6", 12'h158);
        wr_reg("R6", 12'h158, 32'h1234_5678); rd_reg("R6", 12'h158);
        // R11: push and pop in the same cycle
        step("R11", 1'b1, 1'b0, 12'h158, '0, 1'b1, 2'd0, 1'b0);
        rd_reg("R11", 12'h158); rd_reg("R11", 12'h148);
        wr_reg("R6", 12'h158, '0); rd_reg("R9", 12'h148);
        // R6: pop on empty ignored
        wr_reg("R6", 12'h15C, '0); rd_reg("R6", 12'h148); rd_reg("R5", 12'h158);
        // R7: now W1C actually clears, irq drops
        wr_reg("R7", 12'h138, 32'h0001_0000); rd_reg("R7", 12'h138);
        // R3: fill to capacity, then overflow
        for (int i = 0; i < DEPTH + 1; i++) event_in("R3", 2'(i), 1'(i));
        rd_reg("R3", 12'h148); rd_reg("R3", 12'h158);
        // R11: full with simultaneous pop: event still dropped
        step("R11", 1'b1, 1'b0, 12'h15C, '0, 1'b1, 2'd2, 1'b1);
        rd_reg("R11", 12'h158);
        event_in("R11", 2'd3, 1'b0); rd_reg("R3", 12'h148);
        // R10: bridge enable, other bits untouched
        wr_reg("R10", 12'h148, 32'hFFFF_FFFF); rd_reg("R10", 12'h148);
        wr_reg("R10", 12'h148, 32'h0); rd_reg("R3", 12'h148);
        // R8: mask off drops irq
        wr_reg("R8", 12'h13C, 32'hFFFE_FFFF); rd_reg("R8", 12'h13C);
        // drain everything
        for (int i = 0; i < DEPTH; i++) wr_reg("R6", 12'h158, '0);
        rd_reg("R9", 12'h148);
        // R1: reset clears sticky overflow and mask
        do_reset();
        rd_reg("R1", 12'h148); rd_reg("R1", 12'h13C); rd_reg("R1", 12'h138);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule